// File: doc/BRIEF.md
# Chained Beam Partial-Sum Stage

This block forms one link in a chain of stages that together build a phased-array beam. Each cycle it can take two packed link words, which hold four delayed complex antenna samples each, add all eight samples, and add a partial sum handed on by the stage before it. It then registers the widened result and sends it down the chain. Eight-bit samples feed a 16-bit real and 16-bit imaginary running sum. The extra bits leave headroom for a few hundred antennas before the range runs out.

A two-bit role input sets where the stage sits in the chain. A first stage takes its upstream term from the board-to-board input, and that input can be switched off so the term counts as zero. Middle and last stages take the upstream term from the chip-to-chip input. First and middle stages send to the next chip, and a last stage sends to the next board. Data arrives in bursts, so the stage joins its inputs on valid strobes. It consumes a sample only when every input it needs is present at the same time, and it signals the take on its ready outputs.

Top module: `beam_chain_stage`

## Requirements
- R1: Within each 64-bit link word, antenna k (k = 0..3) sits in bits [16k+15:16k]. Its real part is the low byte [16k+7:16k] and its imaginary part is the high byte [16k+15:16k+8], both 8-bit two's complement. Link 0 is link_data_i[63:0] and link 1 is link_data_i[127:64].
- R2: The real part of an output is the sign-extended sum of the eight antenna real parts plus the upstream real part. The imaginary part is formed the same way. On the beam-word ports the real part is in bits [15:0] and the imaginary part is in bits [31:16].
- R3: Role 0 (first) takes its upstream term from brd_in_data_i when up_en_i is 1. When up_en_i is 0, the upstream term is zero, brd_in_valid_i is not waited on, and brd_in_ready_o stays 0.
- R4: Roles 1 (middle), 2 (last) and 3 (treated as middle) take the upstream term from chip_in_data_i. In these roles brd_in_data_i and brd_in_valid_i have no effect, and brd_in_ready_o stays 0.
- R5: A result from a stage in role 2 is flagged on brd_out_valid_o. A result from a stage in any other role is flagged on chip_out_valid_o. The two valids are never high together.
- R6: A sample is taken only in a cycle where both link valids are high and the selected upstream valid, if one is needed, is high. In that cycle both link_ready_o bits are 1, and the ready of the selected upstream input is 1. In every other cycle all readies are 0.
- R7: A result appears exactly one clock after the cycle in which its sample is taken. The output valid is high for one cycle per sample taken, and no output valid is high after a cycle with no take.
- R8: A component sum above 32767 is clamped to 32767, and one below -32768 is clamped to -32768. In either case ovf_o is 1 in the same cycle as that result, and ovf_o is 0 in all other cycles.
- R9: While rst is high, and in the first cycle after it, all output valids and ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| role_i | input | 2 | Chain position: 0 first, 1 middle, 2 last, 3 treated as middle |
| up_en_i | input | 1 | First role only: use the board-to-board upstream sum |
| link_data_i | input | 128 | Two packed antenna link words, link 0 in the low 64 bits |
| link_valid_i | input | 2 | Per-link word valid |
| link_ready_o | output | 2 | Per-link word taken this cycle |
| brd_in_data_i | input | 32 | Upstream partial sum from the previous board |
| brd_in_valid_i | input | 1 | Board upstream sum valid |
| brd_in_ready_o | output | 1 | Board upstream sum taken this cycle |
| chip_in_data_i | input | 32 | Upstream partial sum from the previous chip |
| chip_in_valid_i | input | 1 | Chip upstream sum valid |
| chip_in_ready_o | output | 1 | Chip upstream sum taken this cycle |
| chip_out_data_o | output | 32 | Result word toward the next chip |
| chip_out_valid_o | output | 1 | Result valid toward the next chip |
| brd_out_data_o | output | 32 | Result word toward the next board |
| brd_out_valid_o | output | 1 | Result valid toward the next board |
| ovf_o | output | 1 | The result in this cycle was clamped |

## Verification
The bench uses valid patterns where one link, the other link, or the upstream word arrives a cycle early or late. A join that fires on a partial set of valids would emit results from mixed samples or drop inputs. Bursts where every component sits at an extreme push the sums past both ends of the range, one component at a time or both at once. A design that lets the sum wrap would flip a large positive sum to negative, and a flag mistimed by a cycle would mark the wrong beat. Role changes between bursts, the first role with the upstream input switched off, and the spare role code test whether a stage waits on an input it should ignore or sends a result out the wrong port.

// File: rtl/beam_pkg.sv
`timescale 1ns/1ps
package beam_pkg;

    localparam int SAMP_W        = 8;
    localparam int ANTS_PER_LINK = 4;
    localparam int NUM_LINKS     = 2;
    localparam int SUM_W         = 16;

    typedef enum logic [1:0] {
        ROLE_FIRST = 2'd0,
        ROLE_MID   = 2'd1,
        ROLE_LAST  = 2'd2,
        ROLE_SPARE = 2'd3
    } role_e;

    typedef struct packed {
        logic signed [SUM_W-1:0] im;
        logic signed [SUM_W-1:0] re;
    } beam_word_t;

    function automatic logic role_takes_chip(input role_e r);
        return r != ROLE_FIRST;
    endfunction

    function automatic logic role_to_board(input role_e r);
        return r == ROLE_LAST;
    endfunction

endpackage

// File: rtl/beam_link_unpack.sv
`timescale 1ns/1ps
module beam_link_unpack #(
    parameter int ANTS = 4,
    parameter int SW   = 8
) (
    input  logic [2*SW*ANTS-1:0] word_i,
    output logic signed [SW-1:0] re_o [ANTS],
    output logic signed [SW-1:0] im_o [ANTS]
);
    localparam int SLOT_W = 2 * SW;

    for (genvar k = 0; k < ANTS; k++) begin : g_slot
        assign re_o[k] = word_i[k*SLOT_W +: SW];
        assign im_o[k] = word_i[k*SLOT_W + SW +: SW];
    end
endmodule

// File: rtl/beam_add_tree.sv
`timescale 1ns/1ps
module beam_add_tree #(
    parameter int N     = 8,
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic signed [IN_W-1:0]  x_i [N],
    output logic signed [OUT_W-1:0] sum_o
);
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < N; i++) begin
            sum_o = sum_o + OUT_W'(x_i[i]);
        end
    end
endmodule

// File: rtl/beam_join_ctrl.sv
`timescale 1ns/1ps
module beam_join_ctrl
    import beam_pkg::*;
#(
    parameter int LINKS = 2
) (
    input  role_e            role_i,
    input  logic             up_en_i,
    input  logic [LINKS-1:0] link_valid_i,
    input  logic             brd_valid_i,
    input  logic             chip_valid_i,
    output logic             fire_o,
    output logic [LINKS-1:0] link_ready_o,
    output logic             brd_ready_o,
    output logic             chip_ready_o,
    output logic             sel_brd_o,
    output logic             sel_chip_o
);
    logic up_ok;

    always_comb begin
        sel_chip_o   = role_takes_chip(role_i);
        sel_brd_o    = !sel_chip_o && up_en_i;
        if (sel_chip_o)     up_ok = chip_valid_i;
        else if (sel_brd_o) up_ok = brd_valid_i;
        else                up_ok = 1'b1;
        fire_o       = (&link_valid_i) && up_ok;
        link_ready_o = {LINKS{fire_o}};
        brd_ready_o  = fire_o && sel_brd_o;
        chip_ready_o = fire_o && sel_chip_o;
    end
endmodule

// File: rtl/beam_sat_out.sv
`timescale 1ns/1ps
module beam_sat_out #(
    parameter int ACC_W = 18,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire_i,
    input  logic                    to_board_i,
    input  logic signed [ACC_W-1:0] acc_re_i,
    input  logic signed [ACC_W-1:0] acc_im_i,
    output logic [2*OUT_W-1:0]      data_o,
    output logic                    chip_valid_o,
    output logic                    brd_valid_o,
    output logic                    ovf_o
);
    localparam int MAXV = 2**(OUT_W-1) - 1;
    localparam int MINV = -(2**(OUT_W-1));

    // returns {clamped, value}
    function automatic logic [OUT_W:0] clamp(input logic signed [ACC_W-1:0] v);
        if (v > $signed(ACC_W'(MAXV)))      return {1'b1, OUT_W'(MAXV)};
        else if (v < $signed(ACC_W'(MINV))) return {1'b1, OUT_W'(MINV)};
        else                                return {1'b0, v[OUT_W-1:0]};
    endfunction

    logic [OUT_W-1:0] sat_re, sat_im;
    logic             ovf_re, ovf_im;

    always_comb begin
        {ovf_re, sat_re} = clamp(acc_re_i);
        {ovf_im, sat_im} = clamp(acc_im_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o       <= '0;
            chip_valid_o <= 1'b0;
            brd_valid_o  <= 1'b0;
            ovf_o        <= 1'b0;
        end else begin
            chip_valid_o <= fire_i && !to_board_i;
            brd_valid_o  <= fire_i && to_board_i;
            ovf_o        <= fire_i && (ovf_re || ovf_im);
            if (fire_i) data_o <= {sat_im, sat_re};
        end
    end
endmodule

// File: rtl/beam_chain_stage.sv
`timescale 1ns/1ps
module beam_chain_stage
    import beam_pkg::*;
#(
    parameter int SW    = SAMP_W,
    parameter int ANTS  = ANTS_PER_LINK,
    parameter int LINKS = NUM_LINKS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                role_i,
    input  logic                      up_en_i,
    input  logic [LINKS*2*SW*ANTS-1:0] link_data_i,
    input  logic [LINKS-1:0]          link_valid_i,
    output logic [LINKS-1:0]          link_ready_o,
    input  logic [2*SUM_W-1:0]        brd_in_data_i,
    input  logic                      brd_in_valid_i,
    output logic                      brd_in_ready_o,
    input  logic [2*SUM_W-1:0]        chip_in_data_i,
    input  logic                      chip_in_valid_i,
    output logic                      chip_in_ready_o,
    output logic [2*SUM_W-1:0]        chip_out_data_o,
    output logic                      chip_out_valid_o,
    output logic [2*SUM_W-1:0]        brd_out_data_o,
    output logic                      brd_out_valid_o,
    output logic                      ovf_o
);
    localparam int WORD_W = 2 * SW * ANTS;
    localparam int NANT   = LINKS * ANTS;
    localparam int TREE_W = SW + $clog2(NANT) + 1;
    localparam int ACC_W  = SUM_W + 2;

    role_e role;
    assign role = role_e'(role_i);

    // unpack every link word into per-antenna components
    logic signed [SW-1:0] re_lk [LINKS][ANTS];
    logic signed [SW-1:0] im_lk [LINKS][ANTS];
    logic signed [SW-1:0] re_all [NANT];
    logic signed [SW-1:0] im_all [NANT];

    for (genvar l = 0; l < LINKS; l++) begin : g_link
        beam_link_unpack #(.ANTS(ANTS), .SW(SW)) u_unpack (
            .word_i (link_data_i[l*WORD_W +: WORD_W]),
            .re_o   (re_lk[l]),
            .im_o   (im_lk[l])
        );
    end

    always_comb begin
        for (int l = 0; l < LINKS; l++) begin
            for (int k = 0; k < ANTS; k++) begin
                re_all[l*ANTS + k] = re_lk[l][k];
                im_all[l*ANTS + k] = im_lk[l][k];
            end
        end
    end

    logic signed [TREE_W-1:0] tree_re, tree_im;

    beam_add_tree #(.N(NANT), .IN_W(SW), .OUT_W(TREE_W)) u_tree_re (
        .x_i   (re_all),
        .sum_o (tree_re)
    );
    beam_add_tree #(.N(NANT), .IN_W(SW), .OUT_W(TREE_W)) u_tree_im (
        .x_i   (im_all),
        .sum_o (tree_im)
    );

    // input join
    logic fire, sel_brd, sel_chip;

    beam_join_ctrl #(.LINKS(LINKS)) u_join (
        .role_i       (role),
        .up_en_i      (up_en_i),
        .link_valid_i (link_valid_i),
        .brd_valid_i  (brd_in_valid_i),
        .chip_valid_i (chip_in_valid_i),
        .fire_o       (fire),
        .link_ready_o (link_ready_o),
        .brd_ready_o  (brd_in_ready_o),
        .chip_ready_o (chip_in_ready_o),
        .sel_brd_o    (sel_brd),
        .sel_chip_o   (sel_chip)
    );

    // upstream term selection
    beam_word_t brd_w, chip_w, up_w;
    assign brd_w  = beam_word_t'(brd_in_data_i);
    assign chip_w = beam_word_t'(chip_in_data_i);

    always_comb begin
        if (sel_chip)     up_w = chip_w;
        else if (sel_brd) up_w = brd_w;
        else              up_w = '0;
    end

    logic signed [ACC_W-1:0] acc_re, acc_im;
    assign acc_re = ACC_W'(tree_re) + ACC_W'(up_w.re);
    assign acc_im = ACC_W'(tree_im) + ACC_W'(up_w.im);

    logic [2*SUM_W-1:0] out_word;

    beam_sat_out #(.ACC_W(ACC_W), .OUT_W(SUM_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .fire_i       (fire),
        .to_board_i   (role_to_board(role)),
        .acc_re_i     (acc_re),
        .acc_im_i     (acc_im),
        .data_o       (out_word),
        .chip_valid_o (chip_out_valid_o),
        .brd_valid_o  (brd_out_valid_o),
        .ovf_o        (ovf_o)
    );

    assign chip_out_data_o = out_word;
    assign brd_out_data_o  = out_word;
endmodule

// File: rtl/beam_chain_stage_chk.sv
`timescale 1ns/1ps
module beam_chain_stage_chk #(
    parameter int LINKS = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       role_i,
    input logic             up_en_i,
    input logic [LINKS-1:0] link_valid_i,
    input logic [LINKS-1:0] link_ready_o,
    input logic             brd_in_ready_o,
    input logic             chip_in_valid_i,
    input logic             chip_in_ready_o,
    input logic [31:0]      chip_out_data_o,
    input logic             chip_out_valid_o,
    input logic             brd_out_valid_o,
    input logic             ovf_o
);
    logic any_out;
    assign any_out = chip_out_valid_o || brd_out_valid_o;

    // R5
    dest_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chip_out_valid_o, brd_out_valid_o}));

    // R5
    last_to_board_chk: assert property (@(posedge clk) disable iff (rst)
        (link_ready_o[0] && role_i == 2'd2) |=> brd_out_valid_o);

    // R6
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        link_ready_o[0] |-> (&link_valid_i));

    // R6
    chip_ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        chip_in_ready_o |-> (chip_in_valid_i && link_ready_o[0]));

    // R3
    brd_off_chk: assert property (@(posedge clk) disable iff (rst)
        (role_i == 2'd0 && !up_en_i) |-> !brd_in_ready_o);

    // R4
    brd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (role_i != 2'd0) |-> !brd_in_ready_o);

    // R7
    take_to_out_chk: assert property (@(posedge clk) disable iff (rst)
        link_ready_o[0] |=> any_out);

    // R7
    idle_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        !link_ready_o[0] |=> !any_out);

    // R8
    ovf_with_beat_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> any_out);

    // R8
    ovf_clamped_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (chip_out_data_o[15:0] == 16'h7FFF || chip_out_data_o[15:0] == 16'h8000 ||
                   chip_out_data_o[31:16] == 16'h7FFF || chip_out_data_o[31:16] == 16'h8000));
endmodule

bind beam_chain_stage beam_chain_stage_chk #(.LINKS(LINKS)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .role_i           (role_i),
    .up_en_i          (up_en_i),
    .link_valid_i     (link_valid_i),
    .link_ready_o     (link_ready_o),
    .brd_in_ready_o   (brd_in_ready_o),
    .chip_in_valid_i  (chip_in_valid_i),
    .chip_in_ready_o  (chip_in_ready_o),
    .chip_out_data_o  (chip_out_data_o),
    .chip_out_valid_o (chip_out_valid_o),
    .brd_out_valid_o  (brd_out_valid_o),
    .ovf_o            (ovf_o)
);

// File: tb/test_beam_chain_stage.sv
`timescale 1ns/1ps
module test_beam_chain_stage;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   role;
    logic         up_en;
    logic [127:0] link_data;
    logic [1:0]   link_valid;
    logic [1:0]   link_ready;
    logic [31:0]  brd_in_data, chip_in_data;
    logic         brd_in_valid, chip_in_valid;
    logic         brd_in_ready, chip_in_ready;
    logic [31:0]  chip_out_data, brd_out_data;
    logic         chip_out_valid, brd_out_valid;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state: result expected after the next edge
    bit exp_chip_v = 0, exp_brd_v = 0, exp_ovf = 0;
    int exp_re = 0, exp_im = 0;

    always #2.5 clk = ~clk;

    beam_chain_stage i_beam_chain_stage (
        .clk              (clk),
        .rst              (rst),
        .role_i           (role),
        .up_en_i          (up_en),
        .link_data_i      (link_data),
        .link_valid_i     (link_valid),
        .link_ready_o     (link_ready),
        .brd_in_data_i    (brd_in_data),
        .brd_in_valid_i   (brd_in_valid),
        .brd_in_ready_o   (brd_in_ready),
        .chip_in_data_i   (chip_in_data),
        .chip_in_valid_i  (chip_in_valid),
        .chip_in_ready_o  (chip_in_ready),
        .chip_out_data_o  (chip_out_data),
        .chip_out_valid_o (chip_out_valid),
        .brd_out_data_o   (brd_out_data),
        .brd_out_valid_o  (brd_out_valid),
        .ovf_o            (ovf)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int clamp16(input int v, inout bit flag);
        if (v > 32767)  begin flag = 1; return 32767;  end
        if (v < -32768) begin flag = 1; return -32768; end
        return v;
    endfunction

    // mode 0: full random, 1: extremes, 2: small values
    task automatic drive(input int mode, input int vpct);
        for (int l = 0; l < 2; l++) link_valid[l] = ($urandom_range(99) < vpct);
        brd_in_valid  = ($urandom_range(99) < vpct);
        chip_in_valid = ($urandom_range(99) < vpct);
        if (mode == 1) begin
            bit pr, pi;
            pr = $urandom_range(1);
            pi = $urandom_range(1);
            for (int s = 0; s < 8; s++) begin
                link_data[s*16 +: 8]     = pr ? 8'h7F : 8'h80;
                link_data[s*16 + 8 +: 8] = pi ? 8'h7F : 8'h80;
            end
            brd_in_data[15:0]   = pr ? 16'(32000 + $urandom_range(767)) : 16'(-32000 - int'($urandom_range(768)));
            brd_in_data[31:16]  = pi ? 16'(31000 + $urandom_range(1767)) : 16'(-31000 - int'($urandom_range(1768)));
            chip_in_data = brd_in_data;
            if ($urandom_range(3) == 0) chip_in_data[31:16] = 16'($urandom_range(200));
        end else if (mode == 2) begin
            for (int s = 0; s < 16; s++) link_data[s*8 +: 8] = 8'(int'($urandom_range(8)) - 4);
            brd_in_data  = {16'(int'($urandom_range(40)) - 20), 16'(int'($urandom_range(40)) - 20)};
            chip_in_data = {16'(int'($urandom_range(40)) - 20), 16'(int'($urandom_range(40)) - 20)};
        end else begin
            link_data    = {$urandom, $urandom, $urandom, $urandom};
            brd_in_data  = $urandom;
            chip_in_data = $urandom;
        end
    endtask

    // one cycle, entered and left at a falling edge
    task automatic step(input int mode, input int vpct);
        bit need_chip, need_brd, take, flag;
        int sr, si, ur, ui;
        logic [31:0] got;
        // outputs from the previous take (R5, R7)
        check("R5", "chip_out_valid", int'(chip_out_valid), int'(exp_chip_v));
        check("R5", "brd_out_valid",  int'(brd_out_valid),  int'(exp_brd_v));
        check("R8", "ovf", int'(ovf), int'(exp_ovf));
        if (exp_chip_v || exp_brd_v) begin
            got = exp_brd_v ? brd_out_data : chip_out_data;
            check("R2", "real", int'($signed(got[15:0])),  exp_re);
            check("R2", "imag", int'($signed(got[31:16])), exp_im);
        end
        drive(mode, vpct);
        #1;
        need_chip = (role != 2'd0);
        need_brd  = (role == 2'd0) && up_en;
        take = link_valid[0] && link_valid[1] &&
               (need_chip ? chip_in_valid : (need_brd ? brd_in_valid : 1'b1));
        // R6 join and readies, R3/R4 board input use
        check("R6", "link_ready", int'(link_ready), take ? 3 : 0);
        check("R4", "brd_in_ready", int'(brd_in_ready), int'(take && need_brd));
        check("R6", "chip_in_ready", int'(chip_in_ready), int'(take && need_chip));
        // R1 unpack, R2 sum
        sr = 0; si = 0;
        for (int s = 0; s < 8; s++) begin
            sr += int'($signed(link_data[s*16 +: 8]));
            si += int'($signed(link_data[s*16 + 8 +: 8]));
        end
        ur = 0; ui = 0;
        if (need_chip) begin
            ur = int'($signed(chip_in_data[15:0]));
            ui = int'($signed(chip_in_data[31:16]));
        end else if (need_brd) begin
            ur = int'($signed(brd_in_data[15:0]));
            ui = int'($signed(brd_in_data[31:16]));
        end
        flag = 0;
        exp_re = clamp16(sr + ur, flag);
        exp_im = clamp16(si + ui, flag);
        exp_ovf    = take && flag;
        exp_chip_v = take && (role != 2'd2);
        exp_brd_v  = take && (role == 2'd2);
        @(negedge clk);
    endtask

    task automatic phase(input int r, input bit en, input int mode, input int vpct, input int n);
        role  = 2'(r);
        up_en = en;
        for (int c = 0; c < n; c++) step(mode, vpct);
    endtask

    initial begin
        rst = 1'b1; role = 2'd0; up_en = 1'b0;
        link_data = '0; link_valid = '0;
        brd_in_data = '0; brd_in_valid = 1'b0;
        chip_in_data = '0; chip_in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9", "chip_out_valid at reset", int'(chip_out_valid), 0);
        check("R9", "brd_out_valid at reset",  int'(brd_out_valid), 0);
        check("R9", "ovf at reset", int'(ovf), 0);
        rst = 1'b0;
        // R3 first role, board input on, then off
        phase(0, 1, 0, 75, 300);
        phase(0, 1, 1, 80, 100);
        phase(0, 1, 2, 100, 60);
        phase(0, 0, 0, 75, 200);
        phase(0, 0, 1, 90, 60);
        // R4 middle and spare role use the chip input
        phase(1, 1, 0, 75, 250);
        phase(1, 0, 1, 80, 100);
        phase(3, 1, 0, 70, 100);
        // R5 last role sends to the board
        phase(2, 1, 0, 75, 250);
        phase(2, 1, 1, 85, 100);
        phase(2, 0, 2, 100, 60);
        // R7 role switches every few cycles, and sparse valids
        for (int b = 0; b < 40; b++) phase(b % 4, b[2], b % 3, 50, 5);
        phase(1, 0, 0, 20, 100);
        // drain the last take
        link_valid = '0; brd_in_valid = 0; chip_in_valid = 0;
        step(0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule